// File: doc/BRIEF.md
# Tape Data-Field Timing Checker

This block watches the read path of a tape controller for the length of one machine cycle and reports two timing faults. The first fault is a missing start of the data field: after the read channel reports phase lock, the start-of-data flag must rise within a number of bit cells. The second fault is a missing inter-block gap: after the end of the postamble is reported, the gap-detected flag must rise within a number of bit cells. Both limits depend on the recording density and on whether the operation is a plain read or a read-back during a write.

Each fault is reported on an active-low status output. The output reads 1 while nothing is wrong. It drops to 0 when its limit expires and stays at 0 until the machine cycle ends. Time is measured only in bit-cell strobes. The phase-lock and end-of-postamble flags start a measurement on their rising edge. At the lowest density neither check is active. The strobes and the track decoding come from outside the block.

Top module: `tape_field_timer`

## Requirements
- R1: After a synchronous reset, and one clock after `cyc_active` is sampled low, both `start_chk_n` and `end_chk_n` read 1.
- R2: After a rising edge of `lock_ok` during an active cycle, if `sod` stays low, `start_chk_n` goes to 0 at the clock edge that registers the N-th `cell_stb`. N is 120 for a write read-back and 168 for a read at mode 2'b00 (6250). N is 52 for a write read-back and 63 for a read at mode 2'b01 (1600). `op_read` is 1 for a read and 0 for a write read-back.
- R3: After a rising edge of `eop`, if `gap_seen` stays low, `end_chk_n` goes to 0 at the N-th strobe. N is 88 (write) or 248 (read) at mode 2'b00, and 20 (write) or 36 (read) at mode 2'b01.
- R4: If the awaited flag (`sod` for the start check, `gap_seen` for the end check) is high at a clock edge before the N-th strobe has been registered, that measurement stops and its status output stays 1.
- R5: With mode 2'b10 or 2'b11 (800), neither check starts and both outputs stay 1.
- R6: Once a status output is 0, it holds 0 for as long as `cyc_active` stays high.
- R7: Strobes that arrive before a trigger edge are not counted. A trigger flag that is already high when the cycle starts, with no rising edge after that, starts no measurement.
- R8: The strobe index at which a status output falls lies within the nominal count ±8 at mode 2'b00, and within ±4 at mode 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_active | input | 1 | Machine cycle in progress |
| cell_stb | input | 1 | One-clock pulse per bit cell |
| mode | input | 2 | Density: 00 = 6250, 01 = 1600, 1x = 800 |
| op_read | input | 1 | 1 = read, 0 = write read-back |
| lock_ok | input | 1 | Phase lock reached (start-check trigger) |
| sod | input | 1 | Start of data field detected |
| eop | input | 1 | End of postamble reached (end-check trigger) |
| gap_seen | input | 1 | Inter-block gap pattern detected |
| start_chk_n | output | 1 | Start-read fault, active low, sticky |
| end_chk_n | output | 1 | End-data fault, active low, sticky |

## Verification
If a cell counter is corrupted or misses an increment, a status output falls some strobes too early or too late. The reference model compares the outputs on every clock, so the mismatch shows up in the cycle after the edge that should have flipped the output. A measurement that keeps running, or a sticky bit that does not clear, shows up the same way. The first case appears as a late fall after the awaited flag. The second appears as a 0 that is still present one clock after the cycle has dropped.

// File: rtl/tft_pkg.sv
package tft_pkg;

    typedef enum logic [1:0] {
        DEN_HIGH = 2'b00,
        DEN_MID  = 2'b01,
        DEN_LOW  = 2'b10,
        DEN_LOW2 = 2'b11
    } density_e;

    localparam int NUM_CHK = 2;
    localparam int CHK_START = 0;
    localparam int CHK_END   = 1;

    function automatic int tft_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/tft_limit_sel.sv
module tft_limit_sel
    import tft_pkg::*;
#(
    parameter int CW            = 8,
    parameter int START_WR_HIGH = 120,
    parameter int START_RD_HIGH = 168,
    parameter int START_WR_MID  = 52,
    parameter int START_RD_MID  = 63,
    parameter int END_WR_HIGH   = 88,
    parameter int END_RD_HIGH   = 248,
    parameter int END_WR_MID    = 20,
    parameter int END_RD_MID    = 36
) (
    input  logic [1:0]    mode,
    input  logic          op_read,
    output logic [CW-1:0] start_lim,
    output logic [CW-1:0] end_lim,
    output logic          enable
);
    density_e den;

    always_comb begin
        den       = density_e'(mode);
        enable    = 1'b1;
        start_lim = '1;
        end_lim   = '1;
        unique case (den)
            DEN_HIGH: begin
                start_lim = op_read ? CW'(START_RD_HIGH) : CW'(START_WR_HIGH);
                end_lim   = op_read ? CW'(END_RD_HIGH)   : CW'(END_WR_HIGH);
            end
            DEN_MID: begin
                start_lim = op_read ? CW'(START_RD_MID) : CW'(START_WR_MID);
                end_lim   = op_read ? CW'(END_RD_MID)   : CW'(END_WR_MID);
            end
            default: enable = 1'b0;
        endcase
    end
endmodule

// File: rtl/tft_window.sv
module tft_window #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cyc_active,
    input  logic          enable,
    input  logic          cell_stb,
    input  logic          trig,
    input  logic          awaited,
    input  logic [CW-1:0] limit,
    output logic          ok_n
);
    typedef struct packed {
        logic          armed;
        logic [CW-1:0] cnt;
        logic          ok_n;
        logic          trig_prev;
    } win_t;

    win_t st_q, st_d;
    logic trig_edge;

    assign trig_edge = trig && !st_q.trig_prev;

    always_comb begin
        st_d           = st_q;
        st_d.trig_prev = trig;
        if (!cyc_active) begin
            st_d.armed = 1'b0;
            st_d.cnt   = '0;
            st_d.ok_n  = 1'b1;
        end else if (trig_edge && enable && !awaited) begin
            st_d.armed = 1'b1;
            st_d.cnt   = '0;
        end else if (st_q.armed) begin
            if (awaited || !enable) begin
                st_d.armed = 1'b0;
            end else if (cell_stb) begin
                if (st_q.cnt == limit - CW'(1)) begin
                    st_d.ok_n  = 1'b0;
                    st_d.armed = 1'b0;
                end else begin
                    st_d.cnt = st_q.cnt + CW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.armed     <= 1'b0;
            st_q.cnt       <= '0;
            st_q.ok_n      <= 1'b1;
            st_q.trig_prev <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ok_n = st_q.ok_n;
endmodule

// File: rtl/tape_field_timer.sv
module tape_field_timer
    import tft_pkg::*;
#(
    parameter int START_WR_HIGH = 120,
    parameter int START_RD_HIGH = 168,
    parameter int START_WR_MID  = 52,
    parameter int START_RD_MID  = 63,
    parameter int END_WR_HIGH   = 88,
    parameter int END_RD_HIGH   = 248,
    parameter int END_WR_MID    = 20,
    parameter int END_RD_MID    = 36
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cyc_active,
    input  logic       cell_stb,
    input  logic [1:0] mode,
    input  logic       op_read,
    input  logic       lock_ok,
    input  logic       sod,
    input  logic       eop,
    input  logic       gap_seen,
    output logic       start_chk_n,
    output logic       end_chk_n
);
    localparam int MAX_LIM = tft_max(tft_max(tft_max(START_WR_HIGH, START_RD_HIGH),
                                             tft_max(START_WR_MID, START_RD_MID)),
                                     tft_max(tft_max(END_WR_HIGH, END_RD_HIGH),
                                             tft_max(END_WR_MID, END_RD_MID)));
    localparam int CW = $clog2(MAX_LIM + 1);

    logic [CW-1:0] lim     [NUM_CHK];
    logic          trig_v  [NUM_CHK];
    logic          await_v [NUM_CHK];
    logic          ok_v    [NUM_CHK];
    logic          en;

    tft_limit_sel #(
        .CW(CW),
        .START_WR_HIGH(START_WR_HIGH), .START_RD_HIGH(START_RD_HIGH),
        .START_WR_MID(START_WR_MID),   .START_RD_MID(START_RD_MID),
        .END_WR_HIGH(END_WR_HIGH),     .END_RD_HIGH(END_RD_HIGH),
        .END_WR_MID(END_WR_MID),       .END_RD_MID(END_RD_MID)
    ) u_sel (
        .mode     (mode),
        .op_read  (op_read),
        .start_lim(lim[CHK_START]),
        .end_lim  (lim[CHK_END]),
        .enable   (en)
    );

    assign trig_v[CHK_START]  = lock_ok;
    assign await_v[CHK_START] = sod;
    assign trig_v[CHK_END]    = eop;
    assign await_v[CHK_END]   = gap_seen;

    for (genvar g = 0; g < NUM_CHK; g++) begin : g_win
        tft_window #(.CW(CW)) u_win (
            .clk       (clk),
            .rst       (rst),
            .cyc_active(cyc_active),
            .enable    (en),
            .cell_stb  (cell_stb),
            .trig      (trig_v[g]),
            .awaited   (await_v[g]),
            .limit     (lim[g]),
            .ok_n      (ok_v[g])
        );
    end

    assign start_chk_n = ok_v[CHK_START];
    assign end_chk_n   = ok_v[CHK_END];
endmodule

// File: rtl/tape_field_timer_chk.sv
module tape_field_timer_chk (
    input logic       clk,
    input logic       rst,
    input logic       cyc_active,
    input logic       cell_stb,
    input logic [1:0] mode,
    input logic       sod,
    input logic       gap_seen,
    input logic       start_chk_n,
    input logic       end_chk_n
);
    p_idle_high_r1: assert property (@(posedge clk) disable iff (rst)
        !cyc_active |=> (start_chk_n && end_chk_n));

    p_start_on_strobe_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(start_chk_n) |-> $past(cell_stb));

    p_end_on_strobe_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(end_chk_n) |-> $past(cell_stb));

    p_sod_stops_r4: assert property (@(posedge clk) disable iff (rst)
        (sod && start_chk_n) |=> start_chk_n);

    p_gap_stops_r4: assert property (@(posedge clk) disable iff (rst)
        (gap_seen && end_chk_n) |=> end_chk_n);

    p_low_density_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (mode[1] && start_chk_n && end_chk_n) |=> (start_chk_n && end_chk_n));

    p_start_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (!start_chk_n && cyc_active) |=> !start_chk_n);

    p_end_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (!end_chk_n && cyc_active) |=> !end_chk_n);
endmodule

bind tape_field_timer tape_field_timer_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cyc_active (cyc_active),
    .cell_stb   (cell_stb),
    .mode       (mode),
    .sod        (sod),
    .gap_seen   (gap_seen),
    .start_chk_n(start_chk_n),
    .end_chk_n  (end_chk_n)
);

// File: tb/tape_field_timer_bench.sv
module tape_field_timer_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cyc_active = 1'b0;
    logic       cell_stb = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       op_read = 1'b0;
    logic       lock_ok = 1'b0;
    logic       sod = 1'b0;
    logic       eop = 1'b0;
    logic       gap_seen = 1'b0;
    logic       start_chk_n;
    logic       end_chk_n;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    tape_field_timer u_tape_field_timer (
        .clk(clk), .rst(rst), .cyc_active(cyc_active), .cell_stb(cell_stb),
        .mode(mode), .op_read(op_read), .lock_ok(lock_ok), .sod(sod),
        .eop(eop), .gap_seen(gap_seen),
        .start_chk_n(start_chk_n), .end_chk_n(end_chk_n)
    );

    function automatic int nominal(input logic [1:0] md, input logic rd, input int which);
        if (md == 2'b00) return (which == 0) ? (rd ? 168 : 120) : (rd ? 248 : 88);
        if (md == 2'b01) return (which == 0) ? (rd ? 63 : 52) : (rd ? 36 : 20);
        return 0;
    endfunction

    task automatic check(input string tag, input int got, input int exp);
        vectors++;
        if (got != exp) begin
            misses++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, got, exp, $time);
        end
    endtask

    // Behavioural reference: per-check state held in integers
    int m_arm [2];
    int m_cnt [2];
    int m_ok  [2] = '{1, 1};
    int m_prv [2];

    always @(posedge clk) begin
        for (int i = 0; i < 2; i++) begin
            int lim;
            int tr;
            int aw;
            lim = nominal(mode, op_read, i);
            tr  = (i == 0) ? int'(lock_ok) : int'(eop);
            aw  = (i == 0) ? int'(sod) : int'(gap_seen);
            if (rst) begin
                m_arm[i] = 0; m_cnt[i] = 0; m_ok[i] = 1; m_prv[i] = 0;
            end else begin
                if (!cyc_active) begin
                    m_arm[i] = 0; m_cnt[i] = 0; m_ok[i] = 1;
                end else if (tr == 1 && m_prv[i] == 0 && lim != 0 && aw == 0) begin
                    m_arm[i] = 1; m_cnt[i] = 0;
                end else if (m_arm[i] == 1) begin
                    if (aw == 1 || lim == 0) m_arm[i] = 0;
                    else if (cell_stb) begin
                        m_cnt[i]++;
                        if (m_cnt[i] == lim) begin
                            m_ok[i] = 0; m_arm[i] = 0;
                        end
                    end
                end
                m_prv[i] = tr;
            end
        end
    end

    // Every-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R2 start_chk_n vs model", int'(start_chk_n), m_ok[0]);
            check("R3 end_chk_n vs model", int'(end_chk_n), m_ok[1]);
        end
    end

    // which: 0 = start check, 1 = end check; stop_at: strobe after which awaited rises (0 = never)
    task automatic run_case(input logic [1:0] md, input logic rd, input int which,
                            input int stop_at, input string tag);
        int nom;
        int fall_at;
        int expf;
        int tol;
        int last;
        int obs;
        nom  = nominal(md, rd, which);
        tol  = (md == 2'b00) ? 8 : 4;
        last = (nom == 0) ? 300 : nom + 6;
        @(negedge clk);
        mode = md; op_read = rd; cyc_active = 1'b1;
        // R7: strobes before the trigger edge must not count
        for (int p = 0; p < 5; p++) begin
            cell_stb = 1'b1; @(negedge clk); cell_stb = 1'b0; @(negedge clk);
        end
        if (which == 0) lock_ok = 1'b1; else eop = 1'b1;
        @(negedge clk);
        fall_at = 0;
        for (int s = 1; s <= last; s++) begin
            cell_stb = 1'b1; @(negedge clk); cell_stb = 1'b0;
            obs = (which == 0) ? int'(start_chk_n) : int'(end_chk_n);
            if (obs == 0 && fall_at == 0) fall_at = s;
            if (stop_at == s) begin
                if (which == 0) sod = 1'b1; else gap_seen = 1'b1;
            end
            @(negedge clk);
        end
        expf = (md[1] || (stop_at != 0 && stop_at < nom)) ? 0 : nom;
        check(tag, fall_at, expf);
        if (expf != 0) begin
            check("R8 fall within tolerance window",
                  int'(fall_at >= nom - tol && fall_at <= nom + tol), 1);
            repeat (5) @(negedge clk);
            check("R6 status held while cycle active",
                  (which == 0) ? int'(start_chk_n) : int'(end_chk_n), 0);
        end
        cyc_active = 1'b0; lock_ok = 1'b0; eop = 1'b0; sod = 1'b0; gap_seen = 1'b0;
        @(negedge clk);
        check("R1 start_chk_n high after cycle end", int'(start_chk_n), 1);
        check("R1 end_chk_n high after cycle end", int'(end_chk_n), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 start_chk_n reset value", int'(start_chk_n), 1);
        check("R1 end_chk_n reset value", int'(end_chk_n), 1);
        rst = 1'b0;
        @(negedge clk);

        run_case(2'b00, 1'b0, 0, 0, "R2 start 6250 write");
        run_case(2'b00, 1'b1, 0, 0, "R2 start 6250 read");
        run_case(2'b01, 1'b0, 0, 0, "R2 start 1600 write");
        run_case(2'b01, 1'b1, 0, 0, "R2 start 1600 read");
        run_case(2'b00, 1'b0, 1, 0, "R3 end 6250 write");
        run_case(2'b00, 1'b1, 1, 0, "R3 end 6250 read");
        run_case(2'b01, 1'b0, 1, 0, "R3 end 1600 write");
        run_case(2'b01, 1'b1, 1, 0, "R3 end 1600 read");
        run_case(2'b00, 1'b1, 0, 100, "R4 sod before limit");
        run_case(2'b01, 1'b0, 1, 19, "R4 gap one strobe before limit");
        run_case(2'b01, 1'b1, 0, 63, "R4 sod after limit still faults");
        run_case(2'b10, 1'b0, 0, 0, "R5 start idle at 800");
        run_case(2'b11, 1'b1, 1, 0, "R5 end idle at 800");

        // R7: trigger already high before the cycle starts gives no edge
        @(negedge clk);
        lock_ok = 1'b1; eop = 1'b1; mode = 2'b01; op_read = 1'b0;
        repeat (2) @(negedge clk);
        cyc_active = 1'b1;
        for (int s = 0; s < 80; s++) begin
            cell_stb = 1'b1; @(negedge clk); cell_stb = 1'b0; @(negedge clk);
        end
        check("R7 start level-high trigger ignored", int'(start_chk_n), 1);
        check("R7 end level-high trigger ignored", int'(end_chk_n), 1);
        cyc_active = 1'b0; lock_ok = 1'b0; eop = 1'b0;
        repeat (2) @(negedge clk);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            vectors++;
            misses++;
            $display("FAIL watchdog R1-wide actual=running expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end
endmodule